// File: doc/BRIEF.md
# Boot Redirection Aperture with Configuration Lock

This block steers memory-client requests during early boot. Each request carries a physical address. If that address falls inside a programmable window, the request is sent to the path that leads to on-chip RAM over a peripheral bus. Every other request goes to DRAM. The window has a lower bound and an upper bound, and both bounds are inclusive. Each bound is built from a 32-bit low word plus high bits. The high bits of both bounds share one register.

Software writes and reads the bounds through a small 32-bit register port. When boot is complete, software closes the window by placing the lower bound above the upper bound. It then sets a lock bit. From that point until reset, the window configuration cannot be changed. After reset the window is already closed, so no request is redirected until software opens it.

The routing decision is made from the address and the current register contents, and it is presented one clock after the request.

Top module: `boot_redirect_aperture`

## Requirements
- R1: After reset, index 0 reads 0xFFFFFFFF, and indices 1, 2 and 3 read 0. No request is routed on-chip.
- R2: A valid request with `{base_hi, base_lo} <= addr <= {top_hi, top_lo}` drives `route_onchip` high one cycle later. This holds at both bounds.
- R3: A valid request whose address lies outside the window drives `route_onchip` low one cycle later.
- R4: Whenever the lower bound is greater than the upper bound, no request is routed on-chip.
- R5: The comparison spans the full address width. The high word keeps the lower-bound high bits in bits [7:0] and the upper-bound high bits in bits [23:16], so two addresses that differ only above bit 31 can route differently.
- R6: Register indices are: 0 lower-bound low word, 1 upper-bound low word, 2 shared high word, 3 lock. A write updates the register and the new value reads back. Unused bits of the high word (mask 0xFF00FF00) read 0.
- R7: Bit 0 of index 3 is the lock bit. Writing 1 sets it. Writing 0 does not clear it. Only reset clears it.
- R8: While the lock bit is set, writes to indices 0, 1 and 2 are ignored. The routing continues to use the earlier window.
- R9: Every register write is acknowledged on `reg_wack` exactly one cycle later. This includes writes that the lock discards.
- R10: `route_vld` equals `req_valid` delayed by one cycle, and `route_onchip` is low whenever `route_vld` is low.
- R11: After the disable pattern is written (lower low word 0xFFFFFFFF, upper low word 0, high word 0), every address routes to DRAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 2 | Register index for both write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the register at `reg_idx` (combinational) |
| reg_wack | output | 1 | Write acknowledge, one cycle after `reg_wr` |
| req_valid | input | 1 | Client request valid |
| req_addr | input | ADDR_W | Client request address |
| route_vld | output | 1 | Registered request valid |
| route_onchip | output | 1 | 1 sends the request to the on-chip path, 0 sends it to DRAM |

## Verification
On every cycle the assertions check four things:
- the lock never drops once it is set;
- the bounds stay frozen while locked;
- every write is acknowledged;
- a request is never routed on-chip while the window is empty, or when there is no valid request.

Some behaviours can only be shown by the bench's scenarios. These are: correct routing at both inclusive bounds, the effect of the high-word bits, masking of unused bits on readback, and the disable pattern. The bench compares every cycle against a behavioural model.

// File: rtl/aperture_pkg.sv
// Package: shared register indices and field placement for the boot aperture.
// Assumes the high-word halves are 16 bits wide each.
package aperture_pkg;
    typedef enum logic [1:0] {
        IDX_BASE_LO = 2'd0,
        IDX_TOP_LO  = 2'd1,
        IDX_HIGH    = 2'd2,
        IDX_LOCK    = 2'd3
    } reg_idx_e;

    localparam int TOP_HI_LSB = 16;
    localparam logic [31:0] BASE_LO_RESET = 32'hFFFF_FFFF;
endpackage

// File: rtl/aperture_regs.sv
// Module: aperture register file with a one-way lock.
// Holds both window bounds and the lock bit. The bounds are read-only
// once the lock is set. Every write is acknowledged one cycle later.
// Assumes 33 <= ADDR_W <= 48, so each high half fits in 16 bits.
module aperture_regs
    import aperture_pkg::*;
#(
    parameter int ADDR_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [1:0]        idx,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              wack,
    output logic              locked,
    output logic [ADDR_W-1:0] base_addr,
    output logic [ADDR_W-1:0] top_addr
);
    localparam int HI_W = ADDR_W - 32;

    logic [31:0]     base_lo_q, top_lo_q;
    logic [HI_W-1:0] base_hi_q, top_hi_q;
    logic            lock_q, wack_q;
    logic            cfg_we;

    // Configuration writes are allowed only while the lock is clear.
    assign cfg_we = wr && !lock_q;

    // Update the bound registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_lo_q <= BASE_LO_RESET;
            top_lo_q  <= '0;
            base_hi_q <= '0;
            top_hi_q  <= '0;
        end else if (cfg_we) begin
            case (reg_idx_e'(idx))
                IDX_BASE_LO: base_lo_q <= wdata;
                IDX_TOP_LO:  top_lo_q  <= wdata;
                IDX_HIGH: begin
                    base_hi_q <= wdata[HI_W-1:0];
                    top_hi_q  <= wdata[TOP_HI_LSB +: HI_W];
                end
                default: ;
            endcase
        end
    end

    // The lock bit can only be set; reset is the only way to clear it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lock_q <= 1'b0;
        else if (wr && reg_idx_e'(idx) == IDX_LOCK && wdata[0])
            lock_q <= 1'b1;
    end

    // Acknowledge every write, accepted or not.
    always_ff @(posedge clk) begin
        if (!rst_n) wack_q <= 1'b0;
        else        wack_q <= wr;
    end

    // Read-back mux; unused bits read as zero.
    always_comb begin
        rdata = '0;
        case (reg_idx_e'(idx))
            IDX_BASE_LO: rdata = base_lo_q;
            IDX_TOP_LO:  rdata = top_lo_q;
            IDX_HIGH: begin
                rdata[HI_W-1:0]              = base_hi_q;
                rdata[TOP_HI_LSB +: HI_W]    = top_hi_q;
            end
            default:     rdata[0] = lock_q;
        endcase
    end

    assign wack      = wack_q;
    assign locked    = lock_q;
    assign base_addr = {base_hi_q, base_lo_q};
    assign top_addr  = {top_hi_q, top_lo_q};

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);                                       // R7
    AST_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> ($stable(base_addr) && $stable(top_addr)));    // R8
    AST_WRITE_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> wack);                                             // R9
endmodule

// File: rtl/aperture_match.sv
// Module: inclusive range compare, lo <= addr <= hi.
// Gives no hit when lo > hi, so an inverted window is empty.
// Purely combinational.
module aperture_match #(
    parameter int W = 40
) (
    input  logic [W-1:0] addr,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    output logic         hit
);
    // Both bounds are inclusive.
    assign hit = (addr >= lo) && (addr <= hi);
endmodule

// File: rtl/boot_redirect_aperture.sv
// Module: top of the boot redirection aperture.
// Decides per request whether to use the on-chip path or DRAM, using
// the current window registers, and registers the decision.
// Assumes one request per cycle with no back-pressure.
module boot_redirect_aperture #(
    parameter int ADDR_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_idx,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              reg_wack,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              route_vld,
    output logic              route_onchip
);
    logic [ADDR_W-1:0] base_addr, top_addr;
    logic              locked;
    logic              in_window;
    logic              vld_q, sel_q;

    aperture_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (reg_wr),
        .idx       (reg_idx),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .wack      (reg_wack),
        .locked    (locked),
        .base_addr (base_addr),
        .top_addr  (top_addr)
    );

    aperture_match #(.W(ADDR_W)) u_match (
        .addr (req_addr),
        .lo   (base_addr),
        .hi   (top_addr),
        .hit  (in_window)
    );

    // Register the route decision together with its valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            sel_q <= 1'b0;
        end else begin
            vld_q <= req_valid;
            sel_q <= req_valid && in_window;
        end
    end

    assign route_vld    = vld_q;
    assign route_onchip = sel_q;

    AST_EMPTY_NEVER_ROUTES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (base_addr > top_addr)) |=> !route_onchip);  // R4
    AST_SEL_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        route_onchip |-> route_vld);                               // R10
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> route_vld);                                  // R10
endmodule

// File: tb/tb_boot_redirect_aperture.sv
module tb_boot_redirect_aperture;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_idx = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_wack;
    logic        req_valid = 1'b0;
    logic [39:0] req_addr = '0;
    logic        route_vld, route_onchip;

    int checks = 0, fails = 0;
    bit done = 0;

    // behavioural model state
    logic [31:0] m_blo, m_tlo, m_high;
    bit          m_lock, e_vld, e_sel, e_ack;

    always #2 clk = ~clk;

    boot_redirect_aperture dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_wack(reg_wack),
        .req_valid(req_valid), .req_addr(req_addr),
        .route_vld(route_vld), .route_onchip(route_onchip)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_read(logic [1:0] i);
        case (i)
            2'd0: return m_blo;
            2'd1: return m_tlo;
            2'd2: return m_high;
            default: return {31'b0, m_lock};
        endcase
    endfunction

    function automatic bit m_inside(logic [39:0] a);
        longint unsigned lo, hi, x;
        lo = {24'b0, m_high[7:0], m_blo};
        hi = {24'b0, m_high[23:16], m_tlo};
        x  = {24'b0, a};
        return (x >= lo) && (x <= hi);
    endfunction

    // One clock: advance the model, then compare every output.
    task automatic step(string tag);
        @(posedge clk);
        if (!rst_n) begin
            m_blo = 32'hFFFF_FFFF; m_tlo = 0; m_high = 0; m_lock = 0;
            e_vld = 0; e_sel = 0; e_ack = 0;
        end else begin
            e_vld = req_valid;
            e_sel = req_valid && m_inside(req_addr);
            e_ack = reg_wr;
            if (reg_wr) begin
                if (reg_idx == 2'd3) begin
                    if (reg_wdata[0]) m_lock = 1;
                end else if (!m_lock) begin
                    case (reg_idx)
                        2'd0: m_blo = reg_wdata;
                        2'd1: m_tlo = reg_wdata;
                        default: m_high = reg_wdata & 32'h00FF_00FF;
                    endcase
                end
            end
        end
        #1;
        chk("R10 route_vld", {31'b0, route_vld}, {31'b0, e_vld});
        chk(tag, {31'b0, route_onchip}, {31'b0, e_sel});
        chk("R9 wack", {31'b0, reg_wack}, {31'b0, e_ack});
        chk("R6 rdata", reg_rdata, m_read(reg_idx));
        reg_wr = 0; req_valid = 0;
    endtask

    task automatic wr(logic [1:0] i, logic [31:0] d, string tag);
        reg_wr = 1; reg_idx = i; reg_wdata = d;
        step(tag);
    endtask

    task automatic rd(logic [1:0] i, logic [31:0] exp, string tag);
        reg_idx = i; #1;
        chk(tag, reg_rdata, exp);
        chk(tag, reg_rdata, m_read(i));
    endtask

    task automatic req(logic [39:0] a, bit exp_sel, string tag);
        req_valid = 1; req_addr = a;
        step(tag);
        chk(tag, {31'b0, route_onchip}, {31'b0, exp_sel});
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        #1;
        repeat (3) step("R1 reset");
        rst_n = 1;
        step("R1 idle");
        // R1 reset values and empty window
        rd(2'd0, 32'hFFFF_FFFF, "R1 base_lo");
        rd(2'd1, 32'h0, "R1 top_lo");
        rd(2'd2, 32'h0, "R1 high");
        rd(2'd3, 32'h0, "R1 lock");
        req(40'h00_0000_0000, 0, "R1 addr0");
        req(40'h00_FFFF_FFFF, 0, "R1 addrmax");
        // R2/R3/R5 window 0x01_0000_1000 .. 0x01_0000_2000
        wr(2'd0, 32'h0000_1000, "R6 wr");
        wr(2'd1, 32'h0000_2000, "R6 wr");
        wr(2'd2, 32'h0001_0001, "R6 wr");
        rd(2'd2, 32'h0001_0001, "R6 high");
        req(40'h01_0000_1000, 1, "R2 lower bound");
        req(40'h01_0000_2000, 1, "R2 upper bound");
        req(40'h01_0000_1500, 1, "R2 middle");
        req(40'h01_0000_0FFF, 0, "R3 below");
        req(40'h01_0000_2001, 0, "R3 above");
        req(40'h00_0000_1500, 0, "R5 high bits differ");
        req(40'h02_0000_1500, 0, "R5 high bits above");
        // R10 no request -> no route
        reg_idx = 2'd0; step("R10 idle");
        chk("R10 idle sel", {31'b0, route_onchip}, 32'h0);
        // R4 inverted window
        wr(2'd0, 32'h0000_3000, "R6 wr");
        req(40'h01_0000_2800, 0, "R4 inverted");
        req(40'h01_0000_3000, 0, "R4 inverted base");
        // R6 unused high bits masked
        wr(2'd2, 32'hFFFF_FFFF, "R6 wr");
        rd(2'd2, 32'h00FF_00FF, "R6 mask");
        // R11 disable pattern
        wr(2'd0, 32'hFFFF_FFFF, "R11 wr");
        wr(2'd1, 32'h0, "R11 wr");
        wr(2'd2, 32'h0, "R11 wr");
        req(40'h00_0000_0000, 0, "R11 low");
        req(40'h00_8000_0000, 0, "R11 mid");
        req(40'h00_FFFF_FFFF, 0, "R11 top");
        // R7/R8/R9 lock with an open window
        wr(2'd0, 32'h0000_0100, "R6 wr");
        wr(2'd1, 32'h0000_0200, "R6 wr");
        wr(2'd3, 32'h0000_0001, "R7 set lock");
        rd(2'd3, 32'h1, "R7 lock reads 1");
        wr(2'd3, 32'h0000_0000, "R7 clear try");
        rd(2'd3, 32'h1, "R7 still locked");
        reg_wr = 1; reg_idx = 2'd0; reg_wdata = 32'hFFFF_FFFF;
        step("R9 locked write acked");
        chk("R9 locked ack", {31'b0, reg_wack}, 32'h1);
        wr(2'd1, 32'h0, "R8 wr");
        wr(2'd2, 32'h00FF_00FF, "R8 wr");
        rd(2'd0, 32'h0000_0100, "R8 base kept");
        rd(2'd1, 32'h0000_0200, "R8 top kept");
        rd(2'd2, 32'h0, "R8 high kept");
        req(40'h00_0000_0180, 1, "R8 old window used");
        req(40'h00_0000_0300, 0, "R3 outside locked");
        // R1 reset clears the lock
        rst_n = 0; step("R1 reset"); rst_n = 1; step("R1 idle");
        rd(2'd3, 32'h0, "R1 lock cleared");
        done = 1;
        finish_run();
    end
endmodule